// File: doc/BRIEF.md
# Posted Register Write Tracker

This block sits between a fast bus-side register port and a set of functional registers that are clocked by a slower, unrelated clock. Each write to one of the posted registers is captured into a holding register on the bus side. In posted mode the bus transfer completes in the same cycle. The value is then handed to the functional domain through a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. The functional side holds its own copy of each register and shows that copy on a flat output vector, with a one-cycle update strobe for each register.

Each posted register has a pending flag, and the flags can be read as a bit vector. A flag is set on the bus edge that accepts the write. It clears when the synchronized acknowledge comes back. Software must not write a register again while its flag is set. The block drops such a write and records a sticky error. Reading back a register whose write has not landed returns the old value. When posted mode is turned off, the bus is held in wait states until the functional domain has taken the write. A soft reset command clears the functional copies and reports completion in a status bit.

Address map (index on `bus_addr`): 0..NREG-1 are the posted registers (register index i uses pending bit i); 12 is the pending vector; 13 is interface control (bit 2 = posted mode); 14 is system status (bit 0 = reset done, bit 1 = dropped-write error).

Top module: `posted_wr_tracker`

## Requirements
- R1: After reset the pending vector (address 12) reads 0, interface control (address 13) reads 0x4, system status (address 14) reads 0x1, and the bus is ready.
- R2: In posted mode, a write to a posted register (address 0..NREG-1) completes in its first cycle with `bus_ready` high.
- R3: An accepted write to register index i sets bit i of the pending vector, and the bit is visible from the cycle after acceptance.
- R4: A pending bit clears only after the functional side has applied the write; after that, reading the register returns the written value.
- R5: In posted mode, a write to a register whose pending bit is set is dropped: the register keeps its earlier value and system status bit 1 is set.
- R6: Writes to different registers can be pending at the same time; ten back-to-back writes to indices 0..9 give a pending vector of 0x3FF.
- R7: The error bit stays set until software writes 1 to bit 1 of system status (address 14), or a soft reset is issued.
- R8: With interface control bit 2 cleared, a write to a posted register holds `bus_ready` low until the write has been applied, so the pending vector reads 0 as soon as the write completes.
- R9: Writing 0x06 to interface control starts a soft reset. System status bit 0 reads 0 until the functional side has cleared every register to 0, then reads 1. Posted mode ends up enabled and the error bit is cleared.
- R10: Each accepted write produces exactly one `fn_upd` pulse for its register, with the written value on the matching slice of `fn_regs`. A dropped write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | AW | Register index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while a read is ready |
| bus_ready | output | 1 | Transfer completes on a clock edge while high |
| fn_clk | input | 1 | Functional-domain clock |
| fn_rst_n | input | 1 | Functional-domain asynchronous reset, active low |
| fn_regs | output | NREG*DW | Applied register values, register i in slice i |
| fn_upd | output | NREG | One-cycle strobe per register when a new value lands |
| fn_soft_rst | output | 1 | One-cycle strobe when a soft reset clears the registers |

## Verification
The bench builds the block with its defaults: ten registers, 32-bit data and a 4-bit index. This lets every pending bit be set at once and checks the full 0x3FF vector. The functional clock runs at 41 ns against the 5 ns bus clock. A pending flag therefore stays set for well over ten bus cycles. That is long enough to issue back-to-back writes, repeat writes to a busy register, and observe the pending vector before any acknowledge returns. The same clock ratio makes the non-posted stall last many bus cycles, so a missing wait state cannot go unseen.

// File: rtl/posted_wr_tracker.sv
module posted_wr_tracker #(
  parameter int NREG = 10,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ready,
  input  logic              fn_clk,
  input  logic              fn_rst_n,
  output logic [NREG*DW-1:0] fn_regs,
  output logic [NREG-1:0]   fn_upd,
  output logic              fn_soft_rst
);
  localparam int NCH    = NREG + 1;
  localparam int RST_CH = NREG;
  localparam logic [AW-1:0] A_PEND  = AW'(12);
  localparam logic [AW-1:0] A_ICTL  = AW'(13);
  localparam logic [AW-1:0] A_SSTAT = AW'(14);

  logic [NCH-1:0]  req_t, ack_s1, ack_s2, pend;
  logic [NCH-1:0]  rq_s1, rq_s2, fn_ack_t;
  logic [DW-1:0]   hold   [NREG];
  logic [DW-1:0]   shadow [NREG];
  logic [NREG-1:0] sel;
  logic            posted, err, np_wait;
  logic            is_post, tgt_pend, cap, drop, srst, err_clr;

  assign pend = req_t ^ ack_s2;

  always_comb begin
    for (int i = 0; i < NREG; i++) sel[i] = (bus_addr == AW'(i));
  end

  assign is_post  = |sel;
  assign tgt_pend = |(sel & pend[NREG-1:0]);
  assign cap      = bus_wr && is_post && !tgt_pend && (posted || !np_wait);
  assign drop     = bus_wr && is_post && tgt_pend && posted;
  assign srst     = bus_wr && (bus_addr == A_ICTL) && (bus_wdata[7:0] == 8'h06) && !pend[RST_CH];
  assign err_clr  = bus_wr && (bus_addr == A_SSTAT) && bus_wdata[1];

  always_comb begin
    bus_ready = 1'b1;
    if (!posted && is_post) begin
      if (bus_wr)      bus_ready = np_wait && !tgt_pend;
      else if (bus_rd) bus_ready = !tgt_pend;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) bus_rdata = shadow[i];
    if (bus_addr == A_PEND)  bus_rdata[NREG-1:0] = pend[NREG-1:0];
    if (bus_addr == A_ICTL)  bus_rdata[2] = posted;
    if (bus_addr == A_SSTAT) bus_rdata[1:0] = {err, !pend[RST_CH]};
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_t   <= '0;
      ack_s1  <= '0;
      ack_s2  <= '0;
      posted  <= 1'b1;
      err     <= 1'b0;
      np_wait <= 1'b0;
      for (int i = 0; i < NREG; i++) hold[i] <= '0;
    end else begin
      ack_s1 <= fn_ack_t;
      ack_s2 <= ack_s1;
      for (int i = 0; i < NREG; i++)
        if (cap && sel[i]) begin
          req_t[i] <= ~req_t[i];
          hold[i]  <= bus_wdata;
        end
      if (srst) req_t[RST_CH] <= ~req_t[RST_CH];
      if (bus_wr && bus_addr == A_ICTL) posted <= srst ? 1'b1 : bus_wdata[2];
      if (srst)         err <= 1'b0;
      else if (drop)    err <= 1'b1;
      else if (err_clr) err <= 1'b0;
      if (cap && !posted)            np_wait <= 1'b1;
      else if (np_wait && bus_ready) np_wait <= 1'b0;
    end
  end

  always_ff @(posedge fn_clk or negedge fn_rst_n) begin
    if (!fn_rst_n) begin
      rq_s1       <= '0;
      rq_s2       <= '0;
      fn_ack_t    <= '0;
      fn_upd      <= '0;
      fn_soft_rst <= 1'b0;
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else begin
      rq_s1       <= req_t;
      rq_s2       <= rq_s1;
      fn_ack_t    <= rq_s2;
      fn_upd      <= '0;
      fn_soft_rst <= 1'b0;
      for (int i = 0; i < NREG; i++)
        if (rq_s2[i] != fn_ack_t[i]) begin
          shadow[i] <= hold[i];
          fn_upd[i] <= 1'b1;
        end
      if (rq_s2[RST_CH] != fn_ack_t[RST_CH]) begin
        for (int i = 0; i < NREG; i++) shadow[i] <= '0;
        fn_upd      <= '0;
        fn_soft_rst <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign fn_regs[g*DW +: DW] = shadow[g];
  end
endmodule

module posted_wr_tracker_chk #(
  parameter int NREG = 10,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input logic          bus_clk,
  input logic          bus_rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          posted,
  input logic          err,
  input logic [NREG:0] pend
);
  localparam logic [AW-1:0] C_ICTL  = AW'(13);
  localparam logic [AW-1:0] C_SSTAT = AW'(14);

  logic [NREG-1:0] hit;
  logic            post_hit, busy;

  always_comb begin
    for (int i = 0; i < NREG; i++) hit[i] = (bus_addr == AW'(i));
  end
  assign post_hit = |hit;
  assign busy     = |(hit & pend[NREG-1:0]);

  // R2
  posted_ack_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (posted && bus_wr && post_hit) |-> bus_ready);

  // R3
  pend_set_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (posted && bus_wr && post_hit && !busy) |=> |(pend[NREG-1:0] & $past(hit)));

  // R5
  drop_err_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (posted && bus_wr && busy) |=> err);

  // R7
  err_sticky_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (err && !(bus_wr && bus_addr == C_SSTAT && bus_wdata[1])
         && !(bus_wr && bus_addr == C_ICTL && bus_wdata[7:0] == 8'h06)) |=> err);

  // R8
  np_stall_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (!posted && bus_wr && busy) |-> !bus_ready);
endmodule

bind posted_wr_tracker posted_wr_tracker_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready), .posted(posted), .err(err), .pend(pend)
);

// File: tb/tb_posted_wr_tracker.sv
module tb_posted_wr_tracker;
  localparam int NREG = 10;
  localparam int DW   = 32;
  localparam int AW   = 4;

  logic bus_clk = 0, fn_clk = 0;
  logic bus_rst_n = 0, fn_rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_ready;
  logic [NREG*DW-1:0] fn_regs;
  logic [NREG-1:0] fn_upd;
  logic fn_soft_rst;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_q [NREG][$];

  always #2.5 bus_clk = ~bus_clk;
  always #20.5 fn_clk = ~fn_clk;

  posted_wr_tracker #(.NREG(NREG), .DW(DW), .AW(AW)) dut (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int stalls);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d; stalls = 0;
    #1;
    while (!bus_ready) begin
      @(negedge bus_clk); #1; stalls++;
    end
    rd = bus_rdata;
    @(posedge bus_clk);
    @(negedge bus_clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit push, output int stalls);
    logic [DW-1:0] unused;
    if (push) exp_q[a].push_back(d);
    xfer(1'b1, a, d, unused, stalls);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    int s;
    xfer(1'b0, a, '0, v, s);
  endtask

  task automatic wait_idle(input logic [DW-1:0] mask);
    logic [DW-1:0] v;
    for (int k = 0; k < 400; k++) begin
      rd(AW'(12), v);
      if ((v & mask) == 0) break;
    end
  endtask

  // R10 monitor: pops expected values as updates land
  always @(negedge fn_clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (fn_upd[i]) begin
        if (exp_q[i].size() == 0) begin
          chk("R10 unexpected update", DW'(i), DW'(32'hFFFF));
        end else begin
          chk("R10 applied value", fn_regs[i*DW +: DW], exp_q[i].pop_front());
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int s;
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1; fn_rst_n = 1;
    repeat (2) @(negedge bus_clk);

    // R1 reset state
    #1 chk("R1 ready idle", DW'(bus_ready), 1);
    rd(AW'(12), v); chk("R1 pending", v, 0);
    rd(AW'(13), v); chk("R1 ictl", v, 32'h4);
    rd(AW'(14), v); chk("R1 sstat", v, 32'h1);

    // R2 R3 R4 single posted write
    wr(AW'(2), 32'hA5A5_0001, 1, s);
    chk("R2 no wait states", DW'(s), 0);
    rd(AW'(12), v); chk("R3 pending bit 2", v, 32'h4);
    wait_idle(32'h3FF);
    rd(AW'(12), v); chk("R4 pending cleared", v, 0);
    rd(AW'(2), v); chk("R4 readback", v, 32'hA5A5_0001);

    // R5 write while pending is dropped
    wr(AW'(3), 32'h111, 1, s);
    wr(AW'(3), 32'h222, 0, s);
    chk("R5 dropped write ack", DW'(s), 0);
    rd(AW'(14), v); chk("R5 error flag", v, 32'h3);
    wait_idle(32'h3FF);
    rd(AW'(3), v); chk("R5 first value kept", v, 32'h111);

    // R7 sticky error, write-one-to-clear
    repeat (20) @(negedge bus_clk);
    rd(AW'(14), v); chk("R7 error sticky", v, 32'h3);
    wr(AW'(14), 32'h1, 0, s);
    rd(AW'(14), v); chk("R7 bit1 zero no clear", v, 32'h3);
    wr(AW'(14), 32'h2, 0, s);
    rd(AW'(14), v); chk("R7 error cleared", v, 32'h1);

    // R6 overlapping pending writes
    for (int i = 0; i < NREG; i++) wr(AW'(i), 32'h1000 + i, 1, s);
    rd(AW'(12), v); chk("R6 all pending", v, 32'h3FF);
    wait_idle(32'h3FF);
    for (int i = 0; i < NREG; i++) begin
      rd(AW'(i), v); chk("R6 readback", v, 32'h1000 + i);
    end

    // R8 non-posted mode
    wr(AW'(13), 32'h0, 0, s);
    rd(AW'(13), v); chk("R8 ictl posted off", v, 0);
    wr(AW'(5), 32'hBEEF, 1, s);
    chk("R8 wait states seen", DW'(s > 4), 1);
    rd(AW'(12), v); chk("R8 nothing pending", v, 0);
    rd(AW'(5), v); chk("R8 readback", v, 32'hBEEF);
    wr(AW'(13), 32'h4, 0, s);
    rd(AW'(13), v); chk("R8 ictl posted on", v, 32'h4);

    // R9 soft reset
    wr(AW'(1), 32'h77, 1, s);
    wr(AW'(1), 32'h78, 0, s);
    wait_idle(32'h3FF);
    rd(AW'(14), v); chk("R9 error before reset", v, 32'h2 | 32'h1);
    wr(AW'(13), 32'h6, 0, s);
    rd(AW'(14), v); chk("R9 reset in progress", v, 0);
    for (int k = 0; k < 400; k++) begin
      rd(AW'(14), v);
      if (v[0]) break;
    end
    chk("R9 reset done", v, 32'h1);
    rd(AW'(2), v); chk("R9 reg2 cleared", v, 0);
    rd(AW'(9), v); chk("R9 reg9 cleared", v, 0);
    rd(AW'(1), v); chk("R9 reg1 cleared", v, 0);
    rd(AW'(13), v); chk("R9 posted on", v, 32'h4);

    repeat (40) @(negedge bus_clk);
    for (int i = 0; i < NREG; i++)
      chk("R10 no missing update", DW'(exp_q[i].size()), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule